// File: doc/BRIEF.md
# Session Request Detector for the A-Side of a Dual-Role USB Port

This block sits on the A-device side of a dual-role USB port and decides when the attached B-device is asking for a session. It samples the full-speed and low-speed data lines and a comparator level that says VBUS is above the session-valid threshold. One of two request styles is watched at a time. The first is a pulse on VBUS. The second is a pulse on a data line, where DP serves a full-speed peripheral and DM a low-speed one.

Each line must stay high for a programmable number of clock ticks before the pulse counts. A qualified request raises a sticky flag and a single-cycle interrupt. Firmware turns detection off through an enable bit, for example to keep VBUS off when the battery is low. Switching VBUS on, and any policy for answering the request, belong to the surrounding logic.

Top module: `srp_detect`

## Requirements
- R1: While `det_en` is 0, no activity on any input sets `det_flag` or pulses `det_irq`.
- R2: With `sel_line` = 0 (VBUS mode), the session-valid level must rise and then stay high for `min_vbus_ticks` consecutive synchronized cycles to set the flag. Pulses on DP or DM are ignored in this mode.
- R3: With `sel_line` = 1 (data-line mode), a high run on DP, or a high run on DM, of at least `min_line_ticks` synchronized cycles that ends in a fall sets the flag. VBUS activity is ignored in this mode.
- R4: Shorter runs do not qualify. A threshold of 0 behaves as a threshold of 1.
- R5: A level that is already high when qualification becomes active never counts. The level must first be seen low.
- R6: Every input passes two synchronizer flops. In VBUS mode the flag rises on exactly the (`min_vbus_ticks`+2)-th rising edge after the port level rises. In data-line mode it rises on the 3rd rising edge after the port line falls.
- R7: The flag stays set until `clr_w1c` is 1 at a clock edge, which clears it. If a request qualifies in the same cycle as the clear, the flag stays set.
- R8: `det_irq` is high for exactly one cycle, in the cycle the flag becomes set from clear. A further request while the flag is set raises no interrupt.
- R9: Changing `sel_line`, or clearing `det_en`, in the middle of a pulse discards that pulse. The pulse then gives no detection even if its total length would have qualified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dp_in | input | 1 | DP line state, asynchronous |
| dm_in | input | 1 | DM line state, asynchronous |
| vbus_sess_vld | input | 1 | VBUS above session-valid comparator level, asynchronous |
| det_en | input | 1 | Detection enable |
| sel_line | input | 1 | 0: VBUS-pulse mode, 1: data-line-pulse mode |
| min_line_ticks | input | CNT_W | Minimum high time of a data-line pulse, in clock ticks |
| min_vbus_ticks | input | CNT_W | Minimum hold time of a VBUS rise, in clock ticks |
| clr_w1c | input | 1 | Write-one-to-clear for the detected flag |
| det_flag | output | 1 | Sticky request-detected flag |
| det_irq | output | 1 | One-cycle interrupt pulse when the flag is set |

## Verification
The hardest case to reach is a pulse that would qualify but is cut short by a mode change or a disable. To cover it, the stimulus raises DP, flips `sel_line` away and back for one cycle partway through the run, and then lets the pulse end well past the threshold. It also covers a clear that lands in the same cycle as a qualifying fall. This timing is reached by counting the synchronizer edges from the port fall and driving `clr_w1c` in the cycle before the flag would rise. The pulse-length sweeps step the run length across each threshold for every line and mode.

// File: rtl/srp_pkg.sv
package srp_pkg;

    typedef enum logic {
        QUAL_ON_FALL = 1'b0,
        QUAL_ON_HOLD = 1'b1
    } qual_kind_e;

    localparam int SYNC_W  = 3;
    localparam int IDX_DP  = 0;
    localparam int IDX_DM  = 1;
    localparam int IDX_VB  = 2;
    localparam int N_LINES = 2;

endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stab;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = async_i;
        st_d.stab = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.stab;

endmodule

// File: rtl/srp_pulse_qual.sv
module srp_pulse_qual
    import srp_pkg::*;
#(
    parameter qual_kind_e KIND  = QUAL_ON_HOLD,
    parameter int         CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic             level_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic             hit_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] cnt;
    } qual_st_t;

    qual_st_t         st_d, st_q;
    logic [CNT_W-1:0] thr_eff;
    logic             fall_ok;
    logic             hold_ok;

    assign thr_eff = (thr_i == '0) ? CNT_ONE : thr_i;

    generate
        if (KIND == QUAL_ON_FALL) begin : g_fall
            assign fall_ok = st_q.armed && (st_q.cnt >= thr_eff);
            assign hold_ok = 1'b0;
        end else begin : g_hold
            assign fall_ok = 1'b0;
            assign hold_ok = st_q.armed &&
                             (({1'b0, st_q.cnt} + {{CNT_W{1'b0}}, 1'b1}) == {1'b0, thr_eff});
        end
    endgenerate

    always_comb begin
        st_d  = st_q;
        hit_o = 1'b0;
        if (!active_i) begin
            st_d = '0;
        end else if (!level_i) begin
            hit_o     = fall_ok;
            st_d.armed = 1'b1;
            st_d.cnt   = '0;
        end else if (st_q.armed) begin
            hit_o = hold_ok;
            if (st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + CNT_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_HIT_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> st_q.armed) else $error("hit without prior low level"); // R5

    AST_IDLE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> (st_q.cnt == '0 && !st_q.armed)) else $error("qualifier not flushed"); // R9

endmodule

// File: rtl/srp_detect.sv
module srp_detect
    import srp_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dp_in,
    input  logic             dm_in,
    input  logic             vbus_sess_vld,
    input  logic             det_en,
    input  logic             sel_line,
    input  logic [CNT_W-1:0] min_line_ticks,
    input  logic [CNT_W-1:0] min_vbus_ticks,
    input  logic             clr_w1c,
    output logic             det_flag,
    output logic             det_irq
);

    typedef struct packed {
        logic sel_prev;
        logic flag;
        logic irq;
    } top_st_t;

    top_st_t             st_d, st_q;
    logic [SYNC_W-1:0]   raw_in;
    logic [SYNC_W-1:0]   syn;
    logic [N_LINES-1:0]  line_hit;
    logic                vbus_hit;
    logic                sel_stable;
    logic                act_line;
    logic                act_vbus;
    logic                hit_any;

    assign raw_in[IDX_DP] = dp_in;
    assign raw_in[IDX_DM] = dm_in;
    assign raw_in[IDX_VB] = vbus_sess_vld;

    srp_sync #(.W(SYNC_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (syn)
    );

    assign sel_stable = (sel_line == st_q.sel_prev);
    assign act_line   = det_en &&  sel_line && sel_stable;
    assign act_vbus   = det_en && !sel_line && sel_stable;

    genvar gi;
    generate
        for (gi = 0; gi < N_LINES; gi++) begin : g_line
            srp_pulse_qual #(.KIND(QUAL_ON_FALL), .CNT_W(CNT_W)) u_qual (
                .clk      (clk),
                .rst_n    (rst_n),
                .active_i (act_line),
                .level_i  (syn[gi]),
                .thr_i    (min_line_ticks),
                .hit_o    (line_hit[gi])
            );
        end
    endgenerate

    srp_pulse_qual #(.KIND(QUAL_ON_HOLD), .CNT_W(CNT_W)) u_vbus_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (act_vbus),
        .level_i  (syn[IDX_VB]),
        .thr_i    (min_vbus_ticks),
        .hit_o    (vbus_hit)
    );

    assign hit_any = (|line_hit) || vbus_hit;

    always_comb begin
        st_d          = st_q;
        st_d.sel_prev = sel_line;
        st_d.flag     = hit_any || (st_q.flag && !clr_w1c);
        st_d.irq      = hit_any && (!st_q.flag || clr_w1c);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign det_flag = st_q.flag;
    assign det_irq  = st_q.irq;

    AST_OFF_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !det_en |=> !$rose(det_flag)) else $error("detection while disabled"); // R1

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (det_flag && !clr_w1c) |=> det_flag) else $error("flag dropped without clear"); // R7

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_w1c && !hit_any) |=> !det_flag) else $error("clear ignored"); // R7

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        det_irq |=> !det_irq) else $error("interrupt longer than one cycle"); // R8

    AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        det_irq |-> det_flag) else $error("interrupt without flag"); // R8

endmodule

// File: tb/sim_srp_detect.sv
`timescale 1ns/1ps
module sim_srp_detect;

    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dp_in = 1'b0, dm_in = 1'b0, vbus_sess_vld = 1'b0;
    logic          det_en = 1'b0, sel_line = 1'b0, clr_w1c = 1'b0;
    logic [CW-1:0] min_line_ticks = '0, min_vbus_ticks = '0;
    logic          det_flag, det_irq;

    int n_chk = 0;
    int n_bad = 0;
    int irq_seen = 0;

    always #4 clk = ~clk;

    srp_detect #(.CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .dp_in(dp_in), .dm_in(dm_in),
        .vbus_sess_vld(vbus_sess_vld), .det_en(det_en), .sel_line(sel_line),
        .min_line_ticks(min_line_ticks), .min_vbus_ticks(min_vbus_ticks),
        .clr_w1c(clr_w1c), .det_flag(det_flag), .det_irq(det_irq)
    );

    always @(negedge clk) if (rst_n && det_irq) irq_seen++;

    task automatic chk(input int act, input int exp, input string req);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_line(input int which, input logic v);
        case (which)
            0: dp_in = v;
            1: dm_in = v;
            default: vbus_sess_vld = v;
        endcase
    endtask

    task automatic pulse(input int which, input int n);
        @(negedge clk);
        set_line(which, 1'b1);
        repeat (n) @(negedge clk);
        set_line(which, 1'b0);
        idle(6);
    endtask

    task automatic clear_flag();
        @(negedge clk); clr_w1c = 1'b1;
        @(negedge clk); clr_w1c = 1'b0;
        idle(1);
    endtask

    task automatic try(input int which, input int n, input int exp, input string req);
        int base;
        clear_flag();
        base = irq_seen;
        pulse(which, n);
        chk(det_flag, exp, req);
        chk(irq_seen - base, exp, req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        chk(det_flag, 0, "reset flag");
        chk(det_irq, 0, "reset irq");
        rst_n = 1'b1;
        idle(3);

        // R1: disabled, both modes
        det_en = 1'b0; sel_line = 1'b0; min_vbus_ticks = 2; min_line_ticks = 2;
        idle(4);
        try(2, 8, 0, "R1 vbus disabled");
        sel_line = 1'b1; idle(4);
        try(0, 8, 0, "R1 dp disabled");
        try(1, 8, 0, "R1 dm disabled");

        // R3, R4: data-line sweeps across thresholds
        det_en = 1'b1; sel_line = 1'b1; idle(4);
        for (int t = 2; t <= 4; t += 2) begin
            min_line_ticks = CW'(t); idle(2);
            for (int ln = 0; ln < 2; ln++)
                for (int n = 1; n <= 6; n++)
                    try(ln, n, (n >= t) ? 1 : 0, (n >= t) ? "R3 line pulse" : "R4 short line pulse");
        end
        min_line_ticks = 0; idle(2);
        try(0, 1, 1, "R4 zero threshold line");
        min_line_ticks = 2; idle(2);
        try(2, 8, 0, "R3 vbus ignored in line mode");

        // R2, R4: VBUS sweeps
        sel_line = 1'b0; idle(4);
        for (int t = 2; t <= 4; t += 2) begin
            min_vbus_ticks = CW'(t); idle(2);
            for (int n = 1; n <= 6; n++)
                try(2, n, (n >= t) ? 1 : 0, (n >= t) ? "R2 vbus pulse" : "R4 short vbus pulse");
        end
        min_vbus_ticks = 0; idle(2);
        try(2, 1, 1, "R4 zero threshold vbus");
        min_vbus_ticks = 3; idle(2);
        try(0, 8, 0, "R2 dp ignored in vbus mode");
        try(1, 8, 0, "R2 dm ignored in vbus mode");

        // R6: exact latency, VBUS mode (thr=3 -> flag at 5th edge)
        clear_flag();
        vbus_sess_vld = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(det_flag, 0, "R6 vbus early");
        @(negedge clk);
        chk(det_flag, 1, "R6 vbus on time");
        chk(det_irq, 1, "R8 irq with flag");
        @(negedge clk);
        chk(det_irq, 0, "R8 irq single cycle");
        vbus_sess_vld = 1'b0; idle(6);

        // R8: second request while set gives no irq
        begin
            int base;
            base = irq_seen;
            pulse(2, 6);
            chk(det_flag, 1, "R7 flag held");
            chk(irq_seen - base, 0, "R8 no second irq");
        end
        idle(20);
        chk(det_flag, 1, "R7 sticky over time");
        clear_flag();
        chk(det_flag, 0, "R7 clear");

        // R5: level high before enable never counts
        det_en = 1'b0; idle(2);
        vbus_sess_vld = 1'b1; idle(4);
        det_en = 1'b1; idle(12);
        chk(det_flag, 0, "R5 preexisting high");
        vbus_sess_vld = 1'b0; idle(4);
        try(2, 5, 1, "R5 later real pulse");

        // R6: exact latency, data-line mode (flag at 3rd edge after fall)
        sel_line = 1'b1; min_line_ticks = 3; idle(4);
        clear_flag();
        @(negedge clk); dp_in = 1'b1;
        idle(5);
        dp_in = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(det_flag, 0, "R6 line early");
        @(negedge clk);
        chk(det_flag, 1, "R6 line on time");
        idle(4);

        // R7: clear in the same cycle as a qualifying fall
        clear_flag();
        @(negedge clk); dm_in = 1'b1;
        idle(5);
        dm_in = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk); clr_w1c = 1'b1;
        @(negedge clk); clr_w1c = 1'b0;
        chk(det_flag, 1, "R7 set wins over clear");
        idle(4);

        // R9: select toggled mid pulse
        clear_flag();
        @(negedge clk); dp_in = 1'b1;
        idle(2);
        sel_line = 1'b0;
        @(negedge clk); sel_line = 1'b1;
        idle(6);
        dp_in = 1'b0; idle(6);
        chk(det_flag, 0, "R9 select change aborts");

        // R9: enable dropped mid pulse
        @(negedge clk); dm_in = 1'b1;
        idle(2);
        det_en = 1'b0;
        @(negedge clk); det_en = 1'b1;
        idle(6);
        dm_in = 1'b0; idle(6);
        chk(det_flag, 0, "R9 disable aborts");
        try(1, 4, 1, "R9 recovers after abort");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule